// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block performs hardware handshaking for a serial port using active-low request-to-send and clear-to-send lines. On the receive side it watches the receive FIFO fill count. It releases the RTS line (drives it high) once the count climbs past the selected trigger point, and reclaims it (drives it low) once the count has drained well below that point. The gap between those two thresholds gives the line hysteresis. The receive interrupt and the "room left" indication do not depend on the RTS state, so characters already on their way can still land in the FIFO until it is full.

On the transmit side the block synchronises the incoming CTS line and produces a transmit-allow level. The transmitter samples that level only when it is about to start a new character. When the far end raises CTS, the character in flight finishes, and the allow level then drops. The allow level comes back once CTS returns low. A rising CTS edge can also latch a status flag that software clears by reading it.

Top module: `afc_top`

## Requirements
- R1: One cycle after reset is released, with both automatic modes off, software RTS at 0, and an empty FIFO, the outputs are: rts_n=1, tx_allow=1, cts_flag=0, rx_irq=0, rx_room=1.
- R2: While auto_rts_en=0, rts_n equals the inverse of sw_rts.
- R3: While auto_rts_en=1, rts_n is 1 one clock edge after rx_count reaches the release level. That level depends on trig_code: 0 gives 4, 1 gives 8, 2 gives 14, and 3 gives 14.
- R4: While auto_rts_en=1, rts_n is 0 one clock edge after rx_count is at or below the reclaim level. That level depends on trig_code: 0 gives 0, 1 gives 1, 2 gives 4, and 3 gives 8.
- R5: While auto_rts_en=1 and rx_count lies strictly between the reclaim level and the release level, rts_n keeps its previous value.
- R6: rx_irq is 1 exactly when ien[0]=1 and rx_count is at least the selected level. That level depends on trig_code: 0 gives 1, 1 gives 4, 2 gives 8, and 3 gives 14. The RTS state has no effect on rx_irq.
- R7: rx_room is 1 whenever rx_count is below the FIFO depth of 16, whether or not RTS has been released.
- R8: With auto_cts_en=1, a CTS pin high is seen on the third clock edge after it is driven. From then on, tx_allow falls on the edge where tx_idle=1 or tx_char_done=1, and stays high while a character is still in flight.
- R9: With auto_cts_en=1, tx_allow returns to 1 on the third clock edge after the CTS pin returns low.
- R10: With auto_cts_en=0, tx_allow is 1 whatever the CTS pin does.
- R11: A low-to-high change of the CTS pin sets cts_flag on the third clock edge, but only when ien[1]=1.
- R12: A status_rd pulse clears cts_flag on the next edge, unless a new enabled CTS rise arrives in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_rts_en | input | 1 | Enables automatic RTS control |
| auto_cts_en | input | 1 | Enables CTS gating of transmit starts |
| ien | input | 2 | Interrupt enables: [0] receive trigger, [1] CTS change |
| sw_rts | input | 1 | Software RTS request, used when automatic RTS is off (1 drives pin low) |
| cts_n | input | 1 | Asynchronous active-low clear-to-send pin |
| rx_count | input | 5 | Receive FIFO fill count, 0 to 16 |
| trig_code | input | 2 | Selected receive trigger code |
| tx_idle | input | 1 | Transmitter has no character in flight |
| tx_char_done | input | 1 | Pulse when the transmitter has shifted out a stop bit |
| status_rd | input | 1 | Pulse when software reads the status flag |
| rts_n | output | 1 | Active-low request-to-send pin |
| tx_allow | output | 1 | Transmitter may start a new character |
| cts_flag | output | 1 | Latched CTS-change status |
| rx_irq | output | 1 | Receive trigger interrupt |
| rx_room | output | 1 | Receive FIFO can still accept a character |

## Verification
The hysteresis register is the only memory on the receive side. If it is wrong, rts_n shows the wrong value one edge after the count enters the band between the two levels, and the bench reaches that band from both directions for all four trigger codes. On the CTS path, a wrong stage count in the synchroniser or a wrong gating condition moves the edge where tx_allow or cts_flag changes away from the third edge. Each of those cases is sampled at the exact edge, so a shift of even one cycle shows up as a mismatch.

// File: rtl/afc_pkg.sv
package afc_pkg;

    localparam int FIFO_DEPTH = 16;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        TRIG_1  = 2'd0,
        TRIG_4  = 2'd1,
        TRIG_8  = 2'd2,
        TRIG_14 = 2'd3
    } trig_e;

    typedef struct packed {
        logic high;
        logic rise;
    } cts_sig_t;

    function automatic cnt_t sel_level(trig_e t);
        case (t)
            TRIG_1:  return cnt_t'(1);
            TRIG_4:  return cnt_t'(4);
            TRIG_8:  return cnt_t'(8);
            default: return cnt_t'(14);
        endcase
    endfunction

    function automatic cnt_t release_level(trig_e t);
        case (t)
            TRIG_1:  return cnt_t'(4);
            TRIG_4:  return cnt_t'(8);
            TRIG_8:  return cnt_t'(14);
            default: return cnt_t'(14);
        endcase
    endfunction

    function automatic cnt_t reclaim_level(trig_e t);
        case (t)
            TRIG_1:  return cnt_t'(0);
            TRIG_4:  return cnt_t'(1);
            TRIG_8:  return cnt_t'(4);
            default: return cnt_t'(8);
        endcase
    endfunction

endpackage

// File: rtl/afc_cts_sync.sv
module afc_cts_sync
    import afc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cts_n,
    output cts_sig_t cts
);

    logic [STAGES-1:0] chain;
    logic              last;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= cts_n;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], cts_n};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign cts.high = chain[STAGES-1];
    assign cts.rise = chain[STAGES-1] & ~last;

    a_r11_rise_one_cycle: assert property (@(posedge clk) disable iff (rst)
        cts.rise |=> !cts.rise);

endmodule

// File: rtl/afc_rts_ctrl.sv
module afc_rts_ctrl
    import afc_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  auto_en,
    input  logic  sw_rts,
    input  cnt_t  count,
    input  trig_e trig,
    output logic  rts_n,
    output logic  rx_hit,
    output logic  room
);

    localparam cnt_t DEPTH_C = cnt_t'(DEPTH);

    logic rts_off;
    cnt_t up_lvl, dn_lvl, hit_lvl;

    always_comb begin
        up_lvl  = release_level(trig);
        dn_lvl  = reclaim_level(trig);
        hit_lvl = sel_level(trig);
    end

    always_ff @(posedge clk) begin
        if (rst)                  rts_off <= 1'b1;
        else if (!auto_en)        rts_off <= 1'b1;
        else if (count >= up_lvl) rts_off <= 1'b1;
        else if (count <= dn_lvl) rts_off <= 1'b0;
    end

    assign rts_n  = auto_en ? rts_off : ~sw_rts;
    assign rx_hit = (count >= hit_lvl);
    assign room   = (count < DEPTH_C);

    a_r3_release_upper: assert property (@(posedge clk) disable iff (rst)
        (auto_en && count >= up_lvl) |=> rts_off);

    a_r4_reclaim_lower: assert property (@(posedge clk) disable iff (rst)
        (auto_en && count <= dn_lvl && count < up_lvl) |=> !rts_off);

    a_r5_hold_band: assert property (@(posedge clk) disable iff (rst)
        (auto_en && count > dn_lvl && count < up_lvl) |=> $stable(rts_off));

    a_r7_count_range: assert property (@(posedge clk) disable iff (rst)
        count <= DEPTH_C);

endmodule

// File: rtl/afc_tx_gate.sv
module afc_tx_gate
    import afc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     auto_en,
    input  logic     ien_cts,
    input  cts_sig_t cts,
    input  logic     tx_idle,
    input  logic     char_done,
    input  logic     status_rd,
    output logic     tx_allow,
    output logic     flag
);

    logic set_flag;
    assign set_flag = cts.rise & ien_cts;

    always_ff @(posedge clk) begin
        if (rst)                        tx_allow <= 1'b1;
        else if (!auto_en)              tx_allow <= 1'b1;
        else if (!cts.high)             tx_allow <= 1'b1;
        else if (tx_idle || char_done)  tx_allow <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)            flag <= 1'b0;
        else if (set_flag)  flag <= 1'b1;
        else if (status_rd) flag <= 1'b0;
    end

    a_r8_stop_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (auto_en && cts.high && (tx_idle || char_done)) |=> !tx_allow);

    a_r8_finish_in_flight: assert property (@(posedge clk) disable iff (rst)
        (auto_en && cts.high && !tx_idle && !char_done && tx_allow) |=> tx_allow);

    a_r9_resume: assert property (@(posedge clk) disable iff (rst)
        (auto_en && !cts.high) |=> tx_allow);

    a_r10_ignore_cts: assert property (@(posedge clk) disable iff (rst)
        !auto_en |=> tx_allow);

    a_r11_flag_set: assert property (@(posedge clk) disable iff (rst)
        (cts.rise && ien_cts) |=> flag);

    a_r12_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !(cts.rise && ien_cts)) |=> !flag);

endmodule

// File: rtl/afc_top.sv
module afc_top
    import afc_pkg::*;
#(
    parameter int DEPTH       = FIFO_DEPTH,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic [1:0]       ien,
    input  logic             sw_rts,
    input  logic             cts_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_code,
    input  logic             tx_idle,
    input  logic             tx_char_done,
    input  logic             status_rd,
    output logic             rts_n,
    output logic             tx_allow,
    output logic             cts_flag,
    output logic             rx_irq,
    output logic             rx_room
);

    cts_sig_t cts;
    logic     rx_hit;

    afc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .cts_n (cts_n),
        .cts   (cts)
    );

    afc_rts_ctrl #(.DEPTH(DEPTH)) u_rts (
        .clk     (clk),
        .rst     (rst),
        .auto_en (auto_rts_en),
        .sw_rts  (sw_rts),
        .count   (cnt_t'(rx_count)),
        .trig    (trig_e'(trig_code)),
        .rts_n   (rts_n),
        .rx_hit  (rx_hit),
        .room    (rx_room)
    );

    afc_tx_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .auto_en   (auto_cts_en),
        .ien_cts   (ien[1]),
        .cts       (cts),
        .tx_idle   (tx_idle),
        .char_done (tx_char_done),
        .status_rd (status_rd),
        .tx_allow  (tx_allow),
        .flag      (cts_flag)
    );

    assign rx_irq = ien[0] & rx_hit;

    a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        !ien[0] |-> !rx_irq);

endmodule

// File: tb/tb_afc_top.sv
module tb_afc_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       auto_rts_en = 1'b0, auto_cts_en = 1'b0;
    logic [1:0] ien = 2'b11;
    logic       sw_rts = 1'b0, cts_n = 1'b0;
    logic [4:0] rx_count = '0;
    logic [1:0] trig_code = 2'd0;
    logic       tx_idle = 1'b0, tx_char_done = 1'b0, status_rd = 1'b0;
    logic       rts_n, tx_allow, cts_flag, rx_irq, rx_room;

    always #5 clk = ~clk;

    afc_top dut (
        .clk(clk), .rst(rst), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
        .ien(ien), .sw_rts(sw_rts), .cts_n(cts_n), .rx_count(rx_count),
        .trig_code(trig_code), .tx_idle(tx_idle), .tx_char_done(tx_char_done),
        .status_rd(status_rd), .rts_n(rts_n), .tx_allow(tx_allow),
        .cts_flag(cts_flag), .rx_irq(rx_irq), .rx_room(rx_room)
    );

    // observed bit order: {rts_n, tx_allow, cts_flag, rx_irq, rx_room}
    localparam logic [4:0] M_RTS = 5'b10000, M_ALW = 5'b01000, M_FLG = 5'b00100,
                           M_IRQ = 5'b00010, M_ROOM = 5'b00001, M_ALL = 5'b11111;

    typedef struct {
        string      tag;
        logic [4:0] care;
        logic [4:0] val;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // driver: called at a falling edge after inputs are set; expectation is for the next rising edge
    task automatic tick(string tag, logic [4:0] care, logic [4:0] val);
        exp_t e;
        e.tag = tag; e.care = care; e.val = val;
        q.push_back(e);
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                logic [4:0] obs;
                e   = q.pop_front();
                obs = {rts_n, tx_allow, cts_flag, rx_irq, rx_room};
                if (e.care != 5'b0) begin
                    checks++;
                    if (((obs ^ e.val) & e.care) != 5'b0) begin
                        errors++;
                        $display("FAIL %s: got %b expected %b (mask %b)", e.tag, obs, e.val, e.care);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick("none", 5'b0, 5'b0);
        tick("none", 5'b0, 5'b0);
        rst = 1'b0;
        tick("R1", M_ALL, 5'b11001);

        sw_rts = 1'b1; tick("R2", M_RTS, 5'b00000);
        sw_rts = 1'b0; tick("R2", M_RTS, 5'b10000);

        // trig code 1: hit 4, release 8, reclaim 1
        auto_rts_en = 1'b1; trig_code = 2'd1; rx_count = 5'd0;
        tick("R4", M_RTS, 5'b00000);
        rx_count = 5'd3;  tick("R6", M_RTS | M_IRQ, 5'b00000);
        rx_count = 5'd4;  tick("R6", M_RTS | M_IRQ, 5'b00010);
        rx_count = 5'd7;  tick("R5", M_RTS, 5'b00000);
        rx_count = 5'd8;  tick("R3", M_RTS, 5'b10000);
        rx_count = 5'd5;  tick("R5", M_RTS | M_IRQ, 5'b10010);
        rx_count = 5'd16; tick("R7", M_RTS | M_ROOM, 5'b10000);
        rx_count = 5'd2;  tick("R5", M_RTS | M_ROOM, 5'b10001);
        rx_count = 5'd1;  tick("R4", M_RTS, 5'b00000);

        // trig code 3: hit 14, release 14, reclaim 8
        trig_code = 2'd3;
        rx_count = 5'd13; tick("R5", M_RTS | M_IRQ, 5'b00000);
        rx_count = 5'd14; tick("R3", M_RTS | M_IRQ, 5'b10010);
        rx_count = 5'd9;  tick("R5", M_RTS, 5'b10000);
        rx_count = 5'd8;  tick("R4", M_RTS, 5'b00000);

        // trig code 0: hit 1, release 4, reclaim 0
        trig_code = 2'd0;
        rx_count = 5'd3;  tick("R5", M_RTS | M_IRQ, 5'b00010);
        rx_count = 5'd4;  tick("R3", M_RTS, 5'b10000);
        rx_count = 5'd1;  tick("R5", M_RTS, 5'b10000);
        rx_count = 5'd0;  tick("R4", M_RTS | M_IRQ, 5'b00000);

        // trig code 2: hit 8, release 14, reclaim 4
        trig_code = 2'd2;
        rx_count = 5'd13; tick("R5", M_RTS | M_IRQ, 5'b00010);
        rx_count = 5'd14; tick("R3", M_RTS, 5'b10000);
        rx_count = 5'd5;  tick("R5", M_RTS, 5'b10000);
        rx_count = 5'd4;  tick("R4", M_RTS | M_IRQ, 5'b00000);

        ien = 2'b10; rx_count = 5'd14; tick("R6", M_IRQ, 5'b00000);
        ien = 2'b11; rx_count = 5'd15; tick("R7", M_RTS | M_ROOM, 5'b10001);
        rx_count = 5'd0; tick("none", 5'b0, 5'b0);

        // CTS while a character is in flight
        auto_cts_en = 1'b1; tx_idle = 1'b0; cts_n = 1'b1;
        tick("R8", M_ALW | M_FLG, 5'b01000);
        tick("R8", M_ALW | M_FLG, 5'b01000);
        tick("R11", M_ALW | M_FLG, 5'b01100);
        tx_char_done = 1'b1; tick("R8", M_ALW, 5'b00000);
        tx_char_done = 1'b0; tick("R8", M_ALW, 5'b00000);
        status_rd = 1'b1; tick("R12", M_FLG, 5'b00000);
        status_rd = 1'b0;
        cts_n = 1'b0;
        tick("R9", M_ALW, 5'b00000);
        tick("R9", M_ALW, 5'b00000);
        tick("R9", M_ALW, 5'b01000);

        // CTS with idle transmitter and change interrupt disabled
        tx_idle = 1'b1; ien = 2'b01; cts_n = 1'b1;
        tick("none", 5'b0, 5'b0);
        tick("R8", M_ALW, 5'b01000);
        tick("R11", M_ALW | M_FLG, 5'b00000);
        auto_cts_en = 1'b0; tick("R10", M_ALW, 5'b01000);
        tick("R10", M_ALW | M_FLG, 5'b01000);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule